// File: doc/BRIEF.md
# Duty Ratio Search Engine

This block picks the pair of suspend counts (a run count and a halt count) that makes a clock-gated core come closest to a requested effective frequency. The effective frequency of a pair is the full-speed (stock) frequency scaled by the run count over the sum of both counts. A request carries three values: the target frequency, the stock frequency and the longest total period allowed, in count units. The engine tries every total period from that limit down to one. It keeps the best pair it has found and reports that pair together with the frequency the pair actually gives.

Every candidate costs two products and two quotients. One shared shift-add multiplier and one restoring divider compute them, one bit per cycle. A search over the full range of 255 periods therefore takes thousands of cycles. A host hands over a request with a valid/ready exchange. The engine takes no new request until it has delivered the result of the current one, and it delivers that result as a single-cycle valid pulse.

Top module: `duty_search`

## Requirements
- R1: After reset, `req_ready` is 1 and `res_valid` is 0.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the result has been delivered. While `req_ready` is 0, the values on `req_valid` and the request inputs have no effect on the result.
- R3: `res_valid` is high for exactly one cycle per accepted request. `req_ready` is 1 on the cycle that follows.
- R4: For each period i, the candidate run count is floor(req×i/stock) mod 256. The candidate halt count is (i − run) mod 256. The candidate frequency is floor(stock×run/i). Every i from the period limit down to 1 is tried.
- R5: A candidate replaces the best so far when |cand − req| ≤ |best − req|. Because i falls during the search, a tie goes to the smaller period.
- R6: The best pair starts out as run=1, halt=0, frequency=stock. Those values come out unchanged when no candidate is tried.
- R7: A period limit of 0 gives its result with `res_valid` no more than two cycles after acceptance, and tries no candidate.
- R8: A period limit above 255 is treated as 255.
- R9: `res_off`, `res_on` and `res_freq` change only on the cycle where `res_valid` is 1. They hold their values between results.
- R10: Requests where req exceeds stock are handled with the mod-256 wrap of R4, and no special case is made for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; the request is taken when valid is also 1 |
| req_freq | input | FREQ_W | Requested effective frequency |
| stock_freq | input | FREQ_W | Full-speed frequency, must be nonzero |
| max_dur | input | DUR_W | Longest total period, in count units |
| res_valid | output | 1 | One-cycle result strobe |
| res_off | output | CNT_W | Chosen run count (core clocked) |
| res_on | output | CNT_W | Chosen halt count (core suspended) |
| res_freq | output | FREQ_W+CNT_W | Effective frequency the chosen pair gives |

## Verification
The bench builds the engine with FREQ_W=16 and leaves CNT_W at 8 and DUR_W at 16. With these values one candidate takes about 70 cycles, so complete 255-period searches fit easily in the run. Limits above 255 exercise the clamp. A 16-bit frequency is still wide enough for a request above stock to push the run count past 255, which exercises the wrap. Small limits such as 4 make the tie-break order visible through a result that a strict comparison would change.

// File: rtl/duty_search_pkg.sv
package duty_search_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL1,
    ST_DIV1,
    ST_MUL2,
    ST_DIV2,
    ST_CMP,
    ST_FIN,
    ST_DONE
  } ds_state_t;

  function automatic logic [31:0] ds_clog2p1(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) <= v) r++;
    return r;
  endfunction
endpackage

// File: rtl/duty_search_mul.sv
module duty_search_mul #(
  parameter int A_W = 32,
  parameter int B_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [A_W-1:0]       a,
  input  logic [B_W-1:0]       b,
  output logic                 done,
  output logic [A_W+B_W-1:0]   prod
);
  localparam int P_W = A_W + B_W;
  localparam int CW  = duty_search_pkg::ds_clog2p1(B_W);

  logic [P_W-1:0] a_sh;
  logic [B_W-1:0] b_sh;
  logic [CW-1:0]  cnt;
  logic           busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod <= '0;
      a_sh <= '0;
      b_sh <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        prod <= '0;
        a_sh <= P_W'(a);
        b_sh <= b;
        cnt  <= CW'(B_W);
        busy <= 1'b1;
      end else if (busy) begin
        if (b_sh[0]) prod <= prod + a_sh;
        a_sh <= a_sh << 1;
        b_sh <= b_sh >> 1;
        cnt  <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/duty_search_div.sv
module duty_search_div #(
  parameter int N_W = 40,
  parameter int D_W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           done,
  output logic [N_W-1:0] quo
);
  localparam int CW = duty_search_pkg::ds_clog2p1(N_W);

  logic [D_W-1:0] rem;
  logic [D_W-1:0] dvs_r;
  logic [CW-1:0]  cnt;
  logic           busy;
  logic [D_W:0]   trial;
  logic [D_W:0]   diff;
  logic           fits;

  always_comb begin
    trial = {rem, quo[N_W-1]};
    diff  = trial - {1'b0, dvs_r};
    fits  = (trial >= {1'b0, dvs_r});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      dvs_r <= '0;
      quo   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        dvs_r <= divisor;
        quo   <= dividend;
        cnt   <= CW'(N_W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
        quo  <= {quo[N_W-2:0], fits};
        cnt  <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/duty_search_best.sv
module duty_search_best #(
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      init,
  input  logic [FREQ_W-1:0]         init_stock,
  input  logic [FREQ_W-1:0]         init_req,
  input  logic                      upd,
  input  logic [FREQ_W+CNT_W-1:0]   cand_freq,
  input  logic [CNT_W-1:0]          cand_off,
  input  logic [CNT_W-1:0]          cand_on,
  output logic [FREQ_W+CNT_W-1:0]   best_freq,
  output logic [CNT_W-1:0]          best_off,
  output logic [CNT_W-1:0]          best_on
);
  localparam int ACC_W = FREQ_W + CNT_W;

  logic [ACC_W-1:0] req_x;
  logic [ACC_W-1:0] best_err;
  logic [ACC_W-1:0] cand_err;
  logic [ACC_W-1:0] stock_err;

  function automatic logic [ACC_W-1:0] gap(input logic [ACC_W-1:0] x,
                                            input logic [ACC_W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  always_comb begin
    cand_err  = gap(cand_freq, req_x);
    stock_err = gap(ACC_W'(init_stock), ACC_W'(init_req));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_x     <= '0;
      best_err  <= '0;
      best_freq <= '0;
      best_off  <= CNT_W'(1);
      best_on   <= '0;
    end else if (init) begin
      req_x     <= ACC_W'(init_req);
      best_err  <= stock_err;
      best_freq <= ACC_W'(init_stock);
      best_off  <= CNT_W'(1);
      best_on   <= '0;
    end else if (upd && (cand_err <= best_err)) begin
      best_err  <= cand_err;
      best_freq <= cand_freq;
      best_off  <= cand_off;
      best_on   <= cand_on;
    end
  end
endmodule

// File: rtl/duty_search.sv
module duty_search #(
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 8,
  parameter int DUR_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [FREQ_W-1:0]        req_freq,
  input  logic [FREQ_W-1:0]        stock_freq,
  input  logic [DUR_W-1:0]         max_dur,
  output logic                     res_valid,
  output logic [CNT_W-1:0]         res_off,
  output logic [CNT_W-1:0]         res_on,
  output logic [FREQ_W+CNT_W-1:0]  res_freq
);
  import duty_search_pkg::*;

  localparam int ACC_W   = FREQ_W + CNT_W;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  ds_state_t         state;
  logic [FREQ_W-1:0] req_r;
  logic [FREQ_W-1:0] stock_r;
  logic [CNT_W-1:0]  i_r;
  logic [CNT_W-1:0]  off_r;
  logic [CNT_W-1:0]  on_r;
  logic [ACC_W-1:0]  cand_r;
  logic [CNT_W-1:0]  lim;
  logic              accept;

  logic              mul_start, mul_done;
  logic [FREQ_W-1:0] mul_a;
  logic [CNT_W-1:0]  mul_b;
  logic [ACC_W-1:0]  mul_p;

  logic              div_start, div_done;
  logic [FREQ_W-1:0] div_dvs;
  logic [ACC_W-1:0]  div_q;

  logic [ACC_W-1:0]  best_freq;
  logic [CNT_W-1:0]  best_off, best_on;

  always_comb begin
    lim = (max_dur > DUR_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : max_dur[CNT_W-1:0];
    accept    = (state == ST_IDLE) && req_valid;
    req_ready = (state == ST_IDLE);
    res_valid = (state == ST_DONE);

    mul_start = (accept && (lim != '0))
             || ((state == ST_CMP) && (i_r != CNT_W'(1)))
             || ((state == ST_DIV1) && div_done);
    if (state == ST_DIV1) begin
      mul_a = stock_r;
      mul_b = div_q[CNT_W-1:0];
    end else if (state == ST_IDLE) begin
      mul_a = req_freq;
      mul_b = lim;
    end else begin
      mul_a = req_r;
      mul_b = i_r - CNT_W'(1);
    end

    div_start = mul_done && ((state == ST_MUL1) || (state == ST_MUL2));
    div_dvs   = (state == ST_MUL1) ? stock_r : FREQ_W'(i_r);
  end

  duty_search_mul #(.A_W(FREQ_W), .B_W(CNT_W)) u_mul (
    .clk(clk), .rst(rst), .start(mul_start), .a(mul_a), .b(mul_b),
    .done(mul_done), .prod(mul_p)
  );

  duty_search_div #(.N_W(ACC_W), .D_W(FREQ_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .dividend(mul_p),
    .divisor(div_dvs), .done(div_done), .quo(div_q)
  );

  duty_search_best #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_best (
    .clk(clk), .rst(rst), .init(accept), .init_stock(stock_freq),
    .init_req(req_freq), .upd(state == ST_CMP), .cand_freq(cand_r),
    .cand_off(off_r), .cand_on(on_r), .best_freq(best_freq),
    .best_off(best_off), .best_on(best_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      req_r    <= '0;
      stock_r  <= '0;
      i_r      <= '0;
      off_r    <= '0;
      on_r     <= '0;
      cand_r   <= '0;
      res_off  <= CNT_W'(1);
      res_on   <= '0;
      res_freq <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          req_r   <= req_freq;
          stock_r <= stock_freq;
          i_r     <= lim;
          state   <= (lim == '0) ? ST_FIN : ST_MUL1;
        end
        ST_MUL1: if (mul_done) state <= ST_DIV1;
        ST_DIV1: if (div_done) begin
          off_r <= div_q[CNT_W-1:0];
          on_r  <= i_r - div_q[CNT_W-1:0];
          state <= ST_MUL2;
        end
        ST_MUL2: if (mul_done) state <= ST_DIV2;
        ST_DIV2: if (div_done) begin
          cand_r <= div_q;
          state  <= ST_CMP;
        end
        ST_CMP: begin
          if (i_r == CNT_W'(1)) begin
            state <= ST_FIN;
          end else begin
            i_r   <= i_r - CNT_W'(1);
            state <= ST_MUL1;
          end
        end
        ST_FIN: begin
          res_off  <= best_off;
          res_on   <= best_on;
          res_freq <= best_freq;
          state    <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/duty_search_checks.sv
module duty_search_checks #(
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 8,
  parameter int DUR_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [DUR_W-1:0]        max_dur,
  input logic                    res_valid,
  input logic [CNT_W-1:0]        res_off,
  input logic [CNT_W-1:0]        res_on,
  input logic [FREQ_W+CNT_W-1:0] res_freq
);
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (req_ready && !res_valid));

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_ready_after_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> req_ready);

  p_no_pulse_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !res_valid);

  p_zero_limit_fast_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (max_dur == '0)) |=> ##1 res_valid);

  p_zero_limit_initial_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (max_dur == '0)) |=> ##1
      (res_off == CNT_W'(1) && res_on == '0));

  p_hold_off_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_off) |-> res_valid);

  p_hold_on_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_on) |-> res_valid);

  p_hold_freq_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_freq) |-> res_valid);
endmodule

bind duty_search duty_search_checks #(
  .FREQ_W(FREQ_W), .CNT_W(CNT_W), .DUR_W(DUR_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .max_dur(max_dur), .res_valid(res_valid), .res_off(res_off),
  .res_on(res_on), .res_freq(res_freq)
);

// File: tb/sim_duty_search.sv
`timescale 1ns/1ps
module sim_duty_search;
  localparam int FREQ_W = 16;
  localparam int CNT_W  = 8;
  localparam int DUR_W  = 16;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic [FREQ_W-1:0]       req_freq = '0;
  logic [FREQ_W-1:0]       stock_freq = '0;
  logic [DUR_W-1:0]        max_dur = '0;
  logic                    res_valid;
  logic [CNT_W-1:0]        res_off;
  logic [CNT_W-1:0]        res_on;
  logic [FREQ_W+CNT_W-1:0] res_freq;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  duty_search #(.FREQ_W(FREQ_W), .CNT_W(CNT_W), .DUR_W(DUR_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_freq(req_freq), .stock_freq(stock_freq), .max_dur(max_dur),
    .res_valid(res_valid), .res_off(res_off), .res_on(res_on),
    .res_freq(res_freq)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference search taken from the requirement text (R4, R5, R6, R8).
  task automatic model(input longint rq, input longint st, input longint md,
                       output longint off, output longint on, output longint fr);
    longint lim;
    lim = (md > 255) ? 255 : md;
    off = 1; on = 0; fr = st;
    for (longint i = lim; i > 0; i--) begin
      longint c_off, c_on, c_fr, e_c, e_b;
      c_off = ((rq * i) / st) & 255;
      c_on  = (i - c_off) & 255;
      c_fr  = (st * c_off) / i;
      e_c   = (c_fr > rq) ? c_fr - rq : rq - c_fr;
      e_b   = (fr > rq) ? fr - rq : rq - fr;
      if (e_c <= e_b) begin
        off = c_off; on = c_on; fr = c_fr;
      end
    end
  endtask

  task automatic offer(input longint rq, input longint st, input longint md);
    @(negedge clk);
    req_valid  = 1'b1;
    req_freq   = FREQ_W'(rq);
    stock_freq = FREQ_W'(st);
    max_dur    = DUR_W'(md);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic await_result(output int cyc);
    cyc = 0;
    while (!res_valid) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_and_compare(input string tag, input longint rq,
                                 input longint st, input longint md);
    longint e_off, e_on, e_fr;
    int cyc;
    model(rq, st, md, e_off, e_on, e_fr);
    offer(rq, st, md);
    await_result(cyc);
    check({tag, " off"}, res_off, e_off);
    check({tag, " on"}, res_on, e_on);
    check({tag, " freq"}, res_freq, e_fr);
  endtask

  task automatic t_reset();
    check("R1 ready after reset", req_ready, 1);
    check("R1 no result after reset", res_valid, 0);
  endtask

  task automatic t_basic();
    run_and_compare("R4 quarter", 5000, 20000, 16);
    run_and_compare("R4 two-thirds", 13333, 20000, 40);
    run_and_compare("R4 tiny request", 1, 40000, 20);
    run_and_compare("R4 full range", 7777, 20000, 255);
  endtask

  task automatic t_tie();
    // i=4 gives 2/2 at 500, i=2 gives 1/1 at 500; the smaller period wins.
    run_and_compare("R5 tie model", 500, 1000, 4);
    check("R5 tie off", res_off, 1);
    check("R5 tie on", res_on, 1);
    check("R5 tie freq", res_freq, 500);
  endtask

  task automatic t_zero();
    int cyc;
    offer(1234, 20000, 0);
    await_result(cyc);
    check("R7 zero-limit latency", (cyc <= 2) ? 1 : 0, 1);
    check("R6 initial off", res_off, 1);
    check("R6 initial on", res_on, 0);
    check("R6 initial freq", res_freq, 20000);
  endtask

  task automatic t_clamp();
    longint e_off, e_on, e_fr;
    int cyc;
    model(7000, 30000, 255, e_off, e_on, e_fr);
    offer(7000, 30000, 1000);
    await_result(cyc);
    check("R8 clamp off", res_off, e_off);
    check("R8 clamp on", res_on, e_on);
    check("R8 clamp freq", res_freq, e_fr);
  endtask

  task automatic t_above_stock();
    run_and_compare("R10 request above stock", 30000, 20000, 10);
    run_and_compare("R10 run count wraps", 65000, 100, 3);
  endtask

  task automatic t_busy_ignore();
    longint e_off, e_on, e_fr;
    int cyc;
    model(3000, 12000, 12, e_off, e_on, e_fr);
    offer(3000, 12000, 12);
    check("R2 ready low while busy", req_ready, 0);
    req_valid  = 1'b1;
    req_freq   = FREQ_W'(11000);
    stock_freq = FREQ_W'(12000);
    max_dur    = DUR_W'(0);
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    await_result(cyc);
    check("R2 ignored request off", res_off, e_off);
    check("R2 ignored request on", res_on, e_on);
    check("R2 ignored request freq", res_freq, e_fr);
  endtask

  task automatic t_hold();
    logic [CNT_W-1:0] h_off, h_on;
    logic [FREQ_W+CNT_W-1:0] h_fr;
    int cyc;
    offer(9000, 18000, 6);
    await_result(cyc);
    h_off = res_off; h_on = res_on; h_fr = res_freq;
    @(negedge clk);
    check("R3 strobe lasts one cycle", res_valid, 0);
    check("R3 ready after strobe", req_ready, 1);
    repeat (10) @(negedge clk);
    check("R9 off held", res_off, h_off);
    check("R9 on held", res_on, h_on);
    check("R9 freq held", res_freq, h_fr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tie();
    t_zero();
    t_clamp();
    t_above_stock();
    t_busy_ignore();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule